// File: doc/BRIEF.md
# Transmit Buffer Ready-Flag Generator

This block holds the bytes a host queues for transmission in a 32-entry first-in first-out byte buffer. It also produces a registered transmit-ready flag that tells the host whether it may keep writing. The host pushes bytes through a write strobe. The serializer pops them through a read strobe and always sees the oldest stored byte on the read-data output. The flag logic is the same in every serial framing mode.

Two 5-bit thresholds, each held in its own 8-bit control register, shape the flag. The activation threshold says when the buffer has drained enough to accept more bytes. The deactivation threshold says when it has filled enough to stop the host. When the deactivation value is below the activation value, each threshold acts only in one direction of fill change:
- growth past the deactivation level clears the flag;
- draining down to the activation level sets it;
- any other cycle keeps the flag as it was.

When the deactivation value is not below the activation value, only the activation comparison is used.

Top module: `tx_ready_gen`

## Requirements
- R1: After reset the buffer is empty, `tx_rdy_o` is 1, and both threshold registers read 8'h1F.
- R2: Register select 0 addresses the activation register and select 1 addresses the deactivation register. Bits 4:0 of each register are writable. Bits 7:5 always read 0 and writes to them are ignored.
- R3: Bytes leave the buffer in the order they were written. `rd_data_o` shows the oldest stored byte whenever the buffer is not empty.
- R4: The buffer holds 32 bytes. A write while the buffer is full, with no read in the same cycle, is ignored.
- R5: A read while the buffer is empty is ignored. A write in the same cycle is still accepted.
- R6: A simultaneous read and write on a non-empty buffer leaves the byte count unchanged.
- R7: In hysteresis mode (deactivation < activation), the flag goes to 0 when the count has just grown and is at least deactivation + 1.
- R8: In hysteresis mode, the flag goes to 1 when the count has just shrunk and is at most the activation value.
- R9: In hysteresis mode, on any other cycle the flag keeps its value, including when the count is unchanged because of a combined read and write.
- R10: In compare mode (deactivation >= activation), the flag is 1 exactly when the count is at most the activation value.
- R11: The flag is registered. It reflects a count change at the clock edge after the edge that changed the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host byte write strobe |
| wr_data_i | input | 8 | Host byte to queue |
| rd_en_i | input | 1 | Serializer byte read strobe |
| rd_data_o | output | 8 | Oldest byte in the buffer |
| reg_we_i | input | 1 | Threshold register write strobe |
| reg_sel_i | input | 1 | 0 = activation register, 1 = deactivation register |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Selected register read data |
| tx_rdy_o | output | 1 | Transmit-ready flag |

## Verification
The hardest state to reach is the hysteresis band: the count sits between the two thresholds, and the flag value depends on whether the buffer arrived there by filling or by draining. The stimulus programs thresholds of 3 and 10. It fills well past both thresholds and then drains into the band one byte at a time. It then alternates single writes and reads across the activation level. It also holds the count still with combined reads and writes inside the band.

// File: rtl/tx_rdy_pkg.sv
package tx_rdy_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned THR_W   = 5;
  localparam logic [THR_W-1:0] THR_RST = 5'h1F;

  typedef enum logic {
    SEL_ON  = 1'b0,
    SEL_OFF = 1'b1
  } thr_sel_e;
endpackage

// File: rtl/txb_fifo.sv
module txb_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop, do_push;

  assign do_pop  = rd_en_i && (cnt_q != '0);
  assign do_push = wr_en_i && ((cnt_q != FULL_CNT) || do_pop);

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data_o = mem_q[rd_ptr_q];
  assign cnt_o     = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT); // R4
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == FULL_CNT && wr_en_i && !rd_en_i) |=> (cnt_q == FULL_CNT)); // R4
  AST_EMPTY_READ_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && rd_en_i && !wr_en_i) |=> (cnt_q == '0)); // R5
  AST_BOTH_KEEP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && wr_en_i && rd_en_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/txb_thr_regs.sv
module txb_thr_regs
  import tx_rdy_pkg::*;
#(
  parameter int unsigned RW = BYTE_W,
  parameter int unsigned TW = THR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [RW-1:0] wdata_i,
  output logic [RW-1:0] rdata_o,
  output logic [TW-1:0] on_thr_o,
  output logic [TW-1:0] off_thr_o
);
  logic [TW-1:0] thr_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_thr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              thr_q[g] <= TW'(THR_RST);
      else if (we_i && (sel_i == 1'(g)))        thr_q[g] <= wdata_i[TW-1:0];
    end
  end

  assign on_thr_o  = thr_q[SEL_ON];
  assign off_thr_o = thr_q[SEL_OFF];
  assign rdata_o   = {{(RW-TW){1'b0}}, thr_q[sel_i]};

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[RW-1:TW] == '0); // R2
  AST_WRITE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_OFF) |=> (off_thr_o == $past(wdata_i[TW-1:0]))); // R2
endmodule

// File: rtl/txb_rdy_flag.sv
module txb_rdy_flag
  import tx_rdy_pkg::*;
#(
  parameter int unsigned CW = 6,
  parameter int unsigned TW = THR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [TW-1:0] on_thr_i,
  input  logic [TW-1:0] off_thr_i,
  output logic          rdy_o
);
  logic [CW-1:0] cnt_prev_q;
  logic [CW-1:0] on_ext, off_ext;
  logic          hyst, grew, shrank, rdy_q, rdy_d;

  assign on_ext  = CW'(on_thr_i);
  assign off_ext = CW'(off_thr_i);
  assign hyst    = off_thr_i < on_thr_i;
  assign grew    = cnt_i > cnt_prev_q;
  assign shrank  = cnt_i < cnt_prev_q;

  always_comb begin
    rdy_d = rdy_q;
    if (!hyst)                          rdy_d = (cnt_i <= on_ext);
    else if (grew && cnt_i > off_ext)   rdy_d = 1'b0;
    else if (shrank && cnt_i <= on_ext) rdy_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_prev_q <= '0;
      rdy_q      <= 1'b1;
    end else begin
      cnt_prev_q <= cnt_i;
      rdy_q      <= rdy_d;
    end
  end

  assign rdy_o = rdy_q;

  AST_DROP_ON_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hyst && grew && cnt_i >= off_ext + 1'b1) |=> !rdy_o); // R7
  AST_RISE_ON_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hyst && shrank && cnt_i <= on_ext) |=> rdy_o); // R8
  AST_HOLD_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hyst && cnt_i == cnt_prev_q) |=> $stable(rdy_o)); // R9
  AST_COMPARE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hyst) |=> (rdy_o == $past(cnt_i <= on_ext))); // R10
endmodule

// File: rtl/tx_ready_gen.sv
module tx_ready_gen
  import tx_rdy_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              tx_rdy_o
);
  logic [CW-1:0]    cnt;
  logic [THR_W-1:0] on_thr, off_thr;

  txb_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_en_i, .rd_data_o,
    .cnt_o(cnt)
  );

  txb_thr_regs #(.RW(BYTE_W), .TW(THR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .on_thr_o(on_thr), .off_thr_o(off_thr)
  );

  txb_rdy_flag #(.CW(CW), .TW(THR_W)) u_flag (
    .clk_i, .rst_ni, .cnt_i(cnt), .on_thr_i(on_thr), .off_thr_i(off_thr),
    .rdy_o(tx_rdy_o)
  );

  AST_FLAG_LAGS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cnt) && $stable(on_thr) && $stable(off_thr) |=> $stable(tx_rdy_o)); // R11
endmodule

// File: tb/tx_ready_gen_tb.sv
module tx_ready_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, reg_we = 1'b0, reg_sel = 1'b0;
  logic [7:0] wr_data = '0, reg_wdata = '0;
  logic [7:0] rd_data, reg_rdata;
  logic       tx_rdy;

  int checks = 0, failures = 0;

  // bench model state
  logic [7:0] mq[$];
  int         m_cnt = 0, m_prev = 0, m_on = 31, m_off = 31;
  logic       m_flag = 1'b1;
  logic [7:0] wdat = 8'h10;

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [7:0] n;
    logic       exp;
  } row_t;

  // thresholds on=10, off=3 (hysteresis mode)
  localparam row_t ROWS[10] = '{
    '{1'b1, 1'b0, 8'd3,  1'b1},
    '{1'b1, 1'b0, 8'd1,  1'b0},
    '{1'b1, 1'b0, 8'd10, 1'b0},
    '{1'b0, 1'b1, 8'd3,  1'b0},
    '{1'b0, 1'b1, 8'd1,  1'b1},
    '{1'b1, 1'b0, 8'd1,  1'b0},
    '{1'b0, 1'b1, 8'd1,  1'b1},
    '{1'b1, 1'b1, 8'd5,  1'b1},
    '{1'b1, 1'b0, 8'd30, 1'b0},
    '{1'b0, 1'b1, 8'd40, 1'b1}
  };

  tx_ready_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .tx_rdy_o(tx_rdy)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model after posedge
  task automatic cyc(input logic w, input logic r, input logic [7:0] d,
                     input logic rw, input logic rs, input logic [7:0] rd_in);
    bit pop, push;
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = d;
    reg_we = rw; reg_sel = rs; reg_wdata = rd_in;
    #1;
    if (r && m_cnt > 0)
      check(rd_data == mq[0], "R3 read order", rd_data, mq[0]);
    @(posedge clk);
    if (m_off >= m_on)                        m_flag = (m_cnt <= m_on);
    else if (m_cnt > m_prev && m_cnt > m_off) m_flag = 1'b0;
    else if (m_cnt < m_prev && m_cnt <= m_on) m_flag = 1'b1;
    m_prev = m_cnt;
    pop  = r && m_cnt > 0;
    push = w && (m_cnt < 32 || pop);
    if (pop)  void'(mq.pop_front());
    if (push) mq.push_back(d);
    m_cnt = m_cnt + int'(push) - int'(pop);
    if (rw) begin
      if (rs) m_off = int'(rd_in[4:0]);
      else    m_on  = int'(rd_in[4:0]);
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic op(input logic w, input logic r);
    cyc(w, r, wdat, 1'b0, 1'b0, 8'h00);
    wdat = wdat + 8'd1;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic wreg(input logic s, input logic [7:0] v);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, s, v);
  endtask

  task automatic rreg(input logic s, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_sel = s;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1 check(tx_rdy == 1'b1, "R1 flag after reset", tx_rdy, 1);
    rreg(1'b0, 8'h1F, "R1 activation reg reset");
    rreg(1'b1, 8'h1F, "R1 deactivation reg reset");

    // R2 reserved bits
    wreg(1'b1, 8'hFF);
    rreg(1'b1, 8'h1F, "R2 reserved bits read 0");
    wreg(1'b0, 8'hE3);
    rreg(1'b0, 8'h03, "R2 low field writable");
    rreg(1'b1, 8'h1F, "R2 select isolation");

    // table walk: R7 R8 R9 R6 R4 R5
    wreg(1'b0, 8'h0A);
    wreg(1'b1, 8'h03);
    foreach (ROWS[i]) begin
      for (int k = 0; k < int'(ROWS[i].n); k++) op(ROWS[i].wr, ROWS[i].rd);
      idle();
      check(tx_rdy == ROWS[i].exp, $sformatf("R7/R8/R9 row %0d", i), tx_rdy, ROWS[i].exp);
    end

    // R10 compare mode: off=10 >= on=5
    wreg(1'b1, 8'h0A);
    wreg(1'b0, 8'h05);
    idle();
    check(tx_rdy == 1'b1, "R10 empty", tx_rdy, 1);
    repeat (5) op(1'b1, 1'b0);
    idle();
    check(tx_rdy == 1'b1, "R10 count 5", tx_rdy, 1);
    op(1'b1, 1'b0);
    #1 check(tx_rdy == 1'b1, "R11 flag lags one edge", tx_rdy, 1);
    idle();
    check(tx_rdy == 1'b0, "R10 count 6", tx_rdy, 0);
    op(1'b0, 1'b1);
    idle();
    check(tx_rdy == 1'b1, "R10 back to 5", tx_rdy, 1);
    repeat (5) op(1'b0, 1'b1);

    // R4 full write ignored, R3 order kept
    repeat (32) op(1'b1, 1'b0);
    cyc(1'b1, 1'b0, 8'hEE, 1'b0, 1'b0, 8'h00);
    repeat (32) op(1'b0, 1'b1);
    idle();
    check(m_cnt == 0, "R4 model drained", m_cnt, 0);

    // R5 read on empty ignored, write accepted alongside
    op(1'b0, 1'b1);
    cyc(1'b1, 1'b1, 8'h5A, 1'b0, 1'b0, 8'h00);
    #1 check(rd_data == 8'h5A, "R5 write with empty read", rd_data, 8'h5A);
    op(1'b0, 1'b1);

    // R1 reset again mid-run
    repeat (4) op(1'b1, 1'b0);
    @(negedge clk) rst_n = 1'b0;
    #1 check(tx_rdy == 1'b1, "R1 async reset flag", tx_rdy, 1);
    rreg(1'b0, 8'h1F, "R1 activation reg after reset");
    @(negedge clk) rst_n = 1'b1;
    mq.delete(); m_cnt = 0; m_prev = 0; m_on = 31; m_off = 31; m_flag = 1'b1;
    cyc(1'b1, 1'b0, 8'hA5, 1'b0, 1'b0, 8'h00);
    #1 check(rd_data == 8'hA5, "R1 buffer empty after reset", rd_data, 8'hA5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule